// File: doc/BRIEF.md
# Paged Parallel EEPROM Write Sequencer

This block is a host-side bus master that fills one page of a byte-wide parallel EEPROM. A request gives the page number, the byte count and the completion-detect mode. The block then takes bytes one at a time from a valid/ready stream. For each byte it runs a chip-select and write-strobe sequence, and the byte goes to the next location of the page, starting at offset zero.

Once the last byte is loaded, the block keeps the data bus released and polls the device with read cycles until the device reports that its internal programming has finished. It then pulses `done`. If the byte stream stalls so long that the device would close its load window, the block stops and pulses `err_window`. If polling goes on too long, it pulses `err_timeout` in place of `done`.

All strobe phase lengths, the load-gap limit and the polling limit are clock-count parameters.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, all three strobes (`mem_ce_n`, `mem_oe_n`, `mem_we_n`) are high, `mem_dq_oe` is low, and `in_ready`, `busy`, `done`, `err_timeout` and `err_window` are low.
- R2: A request with `len_m1` = L writes exactly L+1 bytes (1 to 256). The k-th accepted byte goes to address {`page_sel`, k}: the page in bits 16..8 and the offset k in bits 7..0, counting up from 0.
- R3: While `mem_we_n` is low, `mem_ce_n` is low, `mem_oe_n` is high and the data bus is driven.
- R4: Every write-strobe low pulse lasts PULSE_CYC clocks. It is preceded by exactly SETUP_CYC clocks with `mem_ce_n` low and both other strobes high.
- R5: While the stream keeps up, consecutive falling edges of `mem_we_n` are at most GAP_LIMIT clocks apart.
- R6: If no byte arrives in time to keep the next write-strobe fall within GAP_LIMIT clocks of the previous one, the block pulses `err_window`, writes no further byte, gives no `done`, and returns to idle.
- R7: Whenever `mem_oe_n` is low, `mem_dq_oe` is low and `mem_we_n` is high.
- R8: With `poll_data_mode` = 0, the block reads the device repeatedly. It pulses `done` once two consecutive reads agree in data bit 6.
- R9: With `poll_data_mode` = 1, every read targets the last address written. The block pulses `done` once data bit 7 of a read equals bit 7 of the last byte written.
- R10: If the device is not ready within POLL_LIMIT clocks of polling, the block pulses `err_timeout` instead of `done` and returns to idle.
- R11: Each request ends in exactly one single-clock pulse on one of `done`, `err_timeout` or `err_window`. `busy` stays high from the accepted request until that pulse.
- R12: `in_ready` is high only while the block waits for a byte, and never while `mem_we_n` or `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| page_sel | input | 9 | Page number, placed on address bits 16..8 |
| len_m1 | input | 8 | Number of bytes minus one |
| poll_data_mode | input | 1 | 0: bit-6 toggle polling, 1: bit-7 data polling |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts the stream byte this cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | Page programmed (one-cycle pulse) |
| err_timeout | output | 1 | Polling limit exceeded (one-cycle pulse) |
| err_window | output | 1 | Byte stream too slow (one-cycle pulse) |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |
| mem_addr | output | 17 | Device address |
| mem_dq_out | output | 8 | Data driven to the device |
| mem_dq_oe | output | 1 | High when `mem_dq_out` drives the bus |
| mem_dq_in | input | 8 | Data read from the device |

## Verification
The assertions assume that `start` is raised only while `busy` is low. They also assume that `in_data` and `mem_dq_in` stay stable around the clock edge where they are sampled. The bench meets both assumptions: it changes every input a short delay after a rising edge and issues each request only from idle. Its device model changes the returned read data only at falling clock edges. That model flips bit 6 on each read and inverts bit 7 of the last written byte while it counts down its busy time, so both polling modes see a realistic ready transition.

// File: rtl/eepw_pkg.sv
// Package: sequencer state encoding shared by the page writer modules.
// Assumes: nothing beyond SystemVerilog 2017 enum support.
package eepw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // waiting for a request
        ST_WAIT  = 3'd1,   // waiting for the next stream byte
        ST_SETUP = 3'd2,   // chip enable low, address/data settle
        ST_PULSE = 3'd3,   // write strobe low
        ST_HOLD  = 3'd4,   // write strobe high, data still driven
        ST_READ  = 3'd5,   // poll read, bus released
        ST_RECOV = 3'd6    // gap between poll reads
    } wr_state_e;

endpackage

// File: rtl/eepw_phase_timer.sv
// Module: down-counter that measures the length of one strobe phase.
// Assumes: load is raised in the cycle before the phase starts; last is
// high in the final cycle of the phase.
module eepw_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);
    logic [TW-1:0] cnt_q;

    // Reload on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (load)              cnt_q <= load_val;
        else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/eepw_gap_guard.sv
// Module: watches the spacing of write-strobe falling edges and flags a
// stream stall that would push the next fall past GAP_LIMIT clocks.
// Assumes: we_fall is high in the last setup cycle (fall on next edge);
// the caller accepts a byte whenever in_valid is high while waiting.
module eepw_gap_guard #(
    parameter int GAP_LIMIT = 40,
    parameter int SETUP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic we_fall,
    input  logic waiting,
    input  logic in_valid,
    output logic win_err
);
    localparam int GW       = $clog2(GAP_LIMIT + 1);
    localparam int WAIT_MAX = GAP_LIMIT - SETUP_CYC - 1;

    logic [GW-1:0] cnt_q;
    logic          armed_q;

    // Count clocks since the last strobe fall, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (we_fall) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (cnt_q != GW'(GAP_LIMIT)) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign win_err = waiting && armed_q && !in_valid && (cnt_q >= GW'(WAIT_MAX));

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (we_fall && armed_q) |-> (cnt_q < GW'(GAP_LIMIT))); // R5
endmodule

// File: rtl/eepw_poll_judge.sv
// Module: decides device readiness from poll reads and times out polling.
// Assumes: sample is high in the last cycle of each poll read, when
// rd_data is valid; clr is raised once per request before polling.
module eepw_poll_judge #(
    parameter int DATA_W     = 8,
    parameter int POLL_LIMIT = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              active,
    input  logic              sample,
    input  logic              data_mode,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] last_data,
    output logic              ready,
    output logic              expired
);
    localparam int CW      = $clog2(POLL_LIMIT + 1);
    localparam int DP_BIT  = DATA_W - 1;
    localparam int TOG_BIT = DATA_W - 2;

    logic [DATA_W-1:0] prev_q;
    logic              have_q;
    logic [CW-1:0]     cnt_q;

    // Keep the previous read for toggle compare, and count polling clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_q <= '0;
            have_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (sample) begin
                prev_q <= rd_data;
                have_q <= 1'b1;
            end
            if (active && cnt_q != CW'(POLL_LIMIT)) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Ready test for the read sampled in this cycle.
    always_comb begin
        if (data_mode) ready = sample && (rd_data[DP_BIT] == last_data[DP_BIT]);
        else           ready = sample && have_q && (rd_data[TOG_BIT] == prev_q[TOG_BIT]);
    end

    assign expired = (cnt_q == CW'(POLL_LIMIT));

    AST_TOGGLE_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !data_mode && !have_q) |-> !ready); // R8
endmodule

// File: rtl/eeprom_page_writer.sv
// Module: top of the page writer. Loads a stream of bytes into one page of
// a byte-wide EEPROM with timed strobes, then polls for completion.
// Assumes: start only while busy is low; mem_dq_in stable at the end of a
// poll read; all phase lengths are at least one clock.
module eeprom_page_writer
    import eepw_pkg::*;
#(
    parameter int PAGE_W     = 9,
    parameter int LO_W       = 8,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 2,
    parameter int PULSE_CYC  = 3,
    parameter int HOLD_CYC   = 1,
    parameter int READ_CYC   = 2,
    parameter int RECOV_CYC  = 1,
    parameter int GAP_LIMIT  = 40,
    parameter int POLL_LIMIT = 600
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [PAGE_W-1:0]       page_sel,
    input  logic [LO_W-1:0]         len_m1,
    input  logic                    poll_data_mode,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    in_ready,
    output logic                    busy,
    output logic                    done,
    output logic                    err_timeout,
    output logic                    err_window,
    output logic                    mem_ce_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [PAGE_W+LO_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]       mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [DATA_W-1:0]       mem_dq_in
);
    localparam int M1     = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int M2     = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
    localparam int M3     = (M1 > M2) ? M1 : M2;
    localparam int PH_MAX = (M3 > RECOV_CYC) ? M3 : RECOV_CYC;
    localparam int TW     = $clog2(PH_MAX + 1);
    localparam int NW     = LO_W + 1;

    wr_state_e         state_q, nxt;
    logic [PAGE_W-1:0] page_q;
    logic [LO_W-1:0]   len_q;
    logic [LO_W-1:0]   lo_q;
    logic [NW-1:0]     loaded_q;
    logic [DATA_W-1:0] data_q;
    logic              mode_q;
    logic              done_q, tmo_q, win_q;

    logic              accept, fin_done, fin_tmo, fin_win, req;
    logic              ph_last, ph_load;
    logic [TW-1:0]     ph_val;
    logic              win_err, poll_ready, poll_expired, poll_sample;
    logic              last_byte;

    assign req       = (state_q == ST_IDLE) && start;
    assign last_byte = (loaded_q == ({1'b0, len_q} + 1'b1));

    // Next-state and end-of-request decisions.
    always_comb begin
        nxt      = state_q;
        accept   = 1'b0;
        fin_done = 1'b0;
        fin_tmo  = 1'b0;
        fin_win  = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (start) nxt = ST_WAIT;
            ST_WAIT: begin
                if (in_valid) begin
                    accept = 1'b1;
                    nxt    = ST_SETUP;
                end else if (win_err) begin
                    fin_win = 1'b1;
                    nxt     = ST_IDLE;
                end
            end
            ST_SETUP: if (ph_last) nxt = ST_PULSE;
            ST_PULSE: if (ph_last) nxt = ST_HOLD;
            ST_HOLD:  if (ph_last) nxt = last_byte ? ST_READ : ST_WAIT;
            ST_READ: begin
                if (ph_last && poll_ready) begin
                    fin_done = 1'b1;
                    nxt      = ST_IDLE;
                end else if (poll_expired) begin
                    fin_tmo = 1'b1;
                    nxt     = ST_IDLE;
                end else if (ph_last) begin
                    nxt = ST_RECOV;
                end
            end
            ST_RECOV: begin
                if (poll_expired) begin
                    fin_tmo = 1'b1;
                    nxt     = ST_IDLE;
                end else if (ph_last) begin
                    nxt = ST_READ;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Phase length for the state being entered.
    always_comb begin
        ph_load = (nxt != state_q);
        unique case (nxt)
            ST_SETUP: ph_val = TW'(SETUP_CYC - 1);
            ST_PULSE: ph_val = TW'(PULSE_CYC - 1);
            ST_HOLD:  ph_val = TW'(HOLD_CYC - 1);
            ST_READ:  ph_val = TW'(READ_CYC - 1);
            ST_RECOV: ph_val = TW'(RECOV_CYC - 1);
            default:  ph_val = '0;
        endcase
    end

    // State register and request/outcome registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            page_q   <= '0;
            len_q    <= '0;
            mode_q   <= 1'b0;
            lo_q     <= '0;
            loaded_q <= '0;
            data_q   <= '0;
            done_q   <= 1'b0;
            tmo_q    <= 1'b0;
            win_q    <= 1'b0;
        end else begin
            state_q <= nxt;
            done_q  <= fin_done;
            tmo_q   <= fin_tmo;
            win_q   <= fin_win;
            if (req) begin
                page_q   <= page_sel;
                len_q    <= len_m1;
                mode_q   <= poll_data_mode;
                loaded_q <= '0;
            end
            if (accept) begin
                lo_q     <= loaded_q[LO_W-1:0];
                data_q   <= in_data;
                loaded_q <= loaded_q + 1'b1;
            end
        end
    end

    // Strobe and bus drive decoded from the state.
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_SETUP, ST_HOLD: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_READ: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign mem_addr    = {page_q, lo_q};
    assign mem_dq_out  = data_q;
    assign in_ready    = (state_q == ST_WAIT);
    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign err_timeout = tmo_q;
    assign err_window  = win_q;
    assign poll_sample = (state_q == ST_READ) && ph_last;

    eepw_phase_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .last(ph_last)
    );

    eepw_gap_guard #(.GAP_LIMIT(GAP_LIMIT), .SETUP_CYC(SETUP_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr(req),
        .we_fall((state_q == ST_SETUP) && ph_last),
        .waiting(state_q == ST_WAIT), .in_valid(in_valid), .win_err(win_err)
    );

    eepw_poll_judge #(.DATA_W(DATA_W), .POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr(req),
        .active((state_q == ST_READ) || (state_q == ST_RECOV)),
        .sample(poll_sample), .data_mode(mode_q), .rd_data(mem_dq_in),
        .last_data(data_q), .ready(poll_ready), .expired(poll_expired)
    );

    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe)); // R3
    AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n)); // R7
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_timeout, err_window})); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_READY_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (mem_we_n && mem_oe_n)); // R12
endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETUP_CYC  = 2;
    localparam int PULSE_CYC  = 3;
    localparam int GAP_LIMIT  = 40;
    localparam int POLL_LIMIT = 600;
    localparam int BUSY_CYC   = 150;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [8:0]  page_sel = '0;
    logic [7:0]  len_m1 = '0;
    logic        poll_data_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, busy, done, err_timeout, err_window;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_page_writer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_sel(page_sel),
        .len_m1(len_m1), .poll_data_mode(poll_data_mode), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .busy(busy), .done(done),
        .err_timeout(err_timeout), .err_window(err_window), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // ---------------- device model and bus monitor (falling edges) ----------
    logic [7:0]  mem [256];
    logic [7:0]  last_d = '0;
    logic [16:0] last_a = '0;
    logic [8:0]  exp_page = '0;
    int   busy_left = 0;
    bit   stuck = 1'b0;
    bit   tog = 1'b0;
    logic busy_flag;
    bit   p_we = 1'b1, p_oe = 1'b1, p_done = 1'b0, have_fall = 1'b0;
    int   pre_run = 0, low_run = 0, gap_cnt = 0, op_wr = 0;
    int   n_done = 0, n_tmo = 0, n_win = 0, n_wr = 0;
    int   page_bad = 0, order_bad = 0, setup_bad = 0, pulse_bad = 0, gap_bad = 0;
    int   rd_cnt = 0, rd_bad = 0, r7_bad = 0, r12_bad = 0, dbl = 0, busy_at_done = 0;

    assign busy_flag = (busy_left > 0) || stuck;
    assign mem_dq_in = busy_flag ? {~last_d[7], tog, last_d[5:0]} : mem[mem_addr[7:0]];

    always @(negedge clk) begin
        if (rst_n) begin
            if (start && !busy) begin
                op_wr = 0;
                have_fall = 1'b0;
            end
            gap_cnt++;
            if (p_we && !mem_we_n) begin
                if (pre_run != SETUP_CYC) setup_bad++;
                if (have_fall && gap_cnt > GAP_LIMIT) gap_bad++;
                gap_cnt = 0;
                have_fall = 1'b1;
            end
            if (!mem_ce_n && mem_we_n && mem_oe_n) pre_run++;
            else pre_run = 0;
            if (!mem_we_n) low_run++;
            if (!p_we && mem_we_n) begin
                if (low_run != PULSE_CYC) pulse_bad++;
                low_run = 0;
                mem[mem_addr[7:0]] = mem_dq_out;
                if (mem_addr[16:8] != exp_page) page_bad++;
                if (mem_addr[7:0] != 8'(op_wr)) order_bad++;
                op_wr++;
                n_wr++;
                last_d = mem_dq_out;
                last_a = mem_addr;
                busy_left = BUSY_CYC;
            end else if (busy_left > 0) begin
                busy_left--;
            end
            if (p_oe && !mem_oe_n) begin
                rd_cnt++;
                if (mem_addr != last_a) rd_bad++;
                if (busy_flag) tog = ~tog;
            end
            if (!mem_oe_n && (mem_dq_oe || !mem_we_n)) r7_bad++;
            if (in_ready && (!mem_we_n || !mem_oe_n)) r12_bad++;
            if (done) begin
                n_done++;
                if (busy_flag) busy_at_done++;
            end
            if (done && p_done) dbl++;
            if (err_timeout) n_tmo++;
            if (err_window) n_win++;
        end
        p_we   = mem_we_n;
        p_oe   = mem_oe_n;
        p_done = done;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(i * 37 + seed);
    endfunction

    task automatic issue(input logic [8:0] pg, input logic [7:0] l, input bit dm);
        tick();
        exp_page = pg;
        page_sel = pg;
        len_m1 = l;
        poll_data_mode = dm;
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    // Feed n bytes; before byte stall_at, hold valid low for stall clocks.
    task automatic stream(input int n, input int seed, input int stall_at, input int stall);
        for (int i = 0; i < n; i++) begin
            int guard = 0;
            if (i == stall_at) begin
                for (int s = 0; s < stall; s++) tick();
            end
            while (!in_ready && busy && guard < 1000) begin
                tick();
                guard++;
            end
            if (!busy) return;
            in_valid = 1'b1;
            in_data = pat(seed, i);
            tick();
            in_valid = 1'b0;
        end
    endtask

    task automatic wait_end(input int d0, input int t0, input int w0, output int clocks);
        clocks = 0;
        while (n_done == d0 && n_tmo == t0 && n_win == w0 && clocks < 5000) begin
            @(negedge clk);
            clocks++;
        end
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes high", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_oe, "R1", "bus released", mem_dq_oe, 0);
        chk(!in_ready && !busy, "R1", "ready/busy low", {in_ready, busy}, 0);
        chk(!done && !err_timeout && !err_window, "R1", "no outcome", {done, err_timeout, err_window}, 0);
    endtask

    task automatic t_page(input logic [8:0] pg, input int n, input bit dm, input int seed);
        int d0 = n_done, t0 = n_tmo, w0 = n_win, wr0 = n_wr, rd0 = rd_cnt, rb0 = rd_bad;
        int pb0 = page_bad, ob0 = order_bad, sb0 = setup_bad, ub0 = pulse_bad, gb0 = gap_bad;
        int r70 = r7_bad, r120 = r12_bad, db0 = dbl, bd0 = busy_at_done;
        int clocks, bad = 0;
        issue(pg, 8'(n - 1), dm);
        chk(busy, "R11", "busy after request", busy, 1);
        stream(n, seed, -1, 0);
        wait_end(d0, t0, w0, clocks);
        chk(n_wr - wr0 == n, "R2", "byte writes", n_wr - wr0, n);
        chk(page_bad == pb0, "R2", "page bits", page_bad - pb0, 0);
        chk(order_bad == ob0, "R2", "offset order", order_bad - ob0, 0);
        for (int i = 0; i < n; i++) if (mem[i] != pat(seed, i)) bad++;
        chk(bad == 0, "R2", "stored bytes", bad, 0);
        chk(setup_bad == sb0, "R4", "setup length", setup_bad - sb0, 0);
        chk(pulse_bad == ub0, "R4", "pulse width", pulse_bad - ub0, 0);
        chk(gap_bad == gb0, "R5", "fall spacing", gap_bad - gb0, 0);
        chk(r70 == r7_bad, "R7", "bus on read", r7_bad - r70, 0);
        chk(r120 == r12_bad, "R12", "ready strobes", r12_bad - r120, 0);
        chk(n_done - d0 == 1 && n_tmo == t0 && n_win == w0, "R11", "single done",
            n_done - d0, 1);
        chk(dbl == db0 && !busy, "R11", "pulse one clock, idle", dbl - db0, 0);
        chk(busy_at_done == bd0, dm ? "R9" : "R8", "done after device idle",
            busy_at_done - bd0, 0);
        if (dm) chk(rd_bad == rb0, "R9", "reads at last address", rd_bad - rb0, 0);
        else    chk(rd_cnt - rd0 >= 2, "R8", "at least two reads", rd_cnt - rd0, 2);
    endtask

    task automatic t_stall();
        int d0 = n_done, t0 = n_tmo, w0 = n_win, wr0 = n_wr, clocks;
        issue(9'h033, 8'd3, 1'b0);
        stream(4, 5, 1, 80);
        wait_end(d0, t0, w0, clocks);
        chk(n_win - w0 == 1, "R6", "window error", n_win - w0, 1);
        chk(n_done == d0 && n_tmo == t0, "R6", "no done", n_done - d0, 0);
        chk(n_wr - wr0 == 1, "R6", "no write after stall", n_wr - wr0, 1);
        chk(!busy, "R6", "back to idle", busy, 0);
        repeat (BUSY_CYC + 5) @(negedge clk);
    endtask

    task automatic t_timeout();
        int d0 = n_done, t0 = n_tmo, w0 = n_win, clocks;
        stuck = 1'b1;
        issue(9'h155, 8'd1, 1'b0);
        stream(2, 9, -1, 0);
        wait_end(d0, t0, w0, clocks);
        chk(n_tmo - t0 == 1, "R10", "timeout pulse", n_tmo - t0, 1);
        chk(n_done == d0, "R10", "no done", n_done - d0, 0);
        chk(clocks >= POLL_LIMIT, "R10", "polling duration", clocks, POLL_LIMIT);
        chk(!busy, "R10", "back to idle", busy, 0);
        stuck = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        $display("FAIL watchdog: actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_page(9'h0A5, 16, 1'b0, 3);     // R8 toggle mode
        t_page(9'h1FF, 256, 1'b1, 11);   // R2 full page, R9 data mode
        t_page(9'h000, 1, 1'b1, 156);    // R2 single byte, bit 7 set
        t_page(9'h0C3, 5, 1'b0, 200);    // R8 short page
        t_stall();                       // R6
        t_timeout();                     // R10
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule